// File: doc/BRIEF.md
# GPIO Pad Configuration Register File

This block holds the pad settings for one port of eight pins. Software reaches it through a plain word-addressed register interface with an address, a write strobe, write data and combinational read data. Each setting is exported as a per-pin vector that goes to the pad ring. The settings are: direction, digital enable, analog select, alternate-function enable, a 4-bit function code per pin, pull-up, pull-down, open-drain, three drive-weight selects and a slew request.

Some pins can be marked as protected in a parameter. For those pins, changes to the alternate-function enable, pull-up, pull-down and digital-enable bits take effect only where a commit mask bit is set. The commit mask can be written only after a 32-bit key has been written to the lock word.

The hardware keeps pull-up and pull-down exclusive per pin. The slew request is exported only for pins whose drive selection is one of the high settings.

Top module: `gpio_padcfg`

Word map, by `addr`:

| Address | Register |
|---|---|
| 0 | direction |
| 1 | digital enable |
| 2 | analog select |
| 3 | alternate-function enable |
| 4 | function codes |
| 5 | pull-up |
| 6 | pull-down |
| 7 | open-drain |
| 8 | 4 mA weight |
| 9 | 8 mA weight |
| 10 | 12 mA weight |
| 11 | slew request |
| 12 | lock |
| 13 | commit mask |

## Requirements
- R1: After reset, every configuration register and output is zero, the lock word reads 1, and the commit mask reads as the complement of the PROT_PINS parameter (default 8'h0C).
- R2: A write to direction, analog select, open-drain, the three drive weights, slew request or function codes stores the value, and it reads back the next cycle. The function-code word holds pin i's code in bits [4i+3:4i], and that value appears on `fsel_o`.
- R3: A pull-down bit is cleared when a 1 is written to the same bit of pull-up (address 5), and a pull-up bit is cleared when a 1 is written to the same bit of pull-down (address 6). No pin ever has both pulls set.
- R4: Writes to alternate-function enable, digital enable, pull-up and pull-down change only the bits whose commit mask bit is 1. All other bits keep their value.
- R5: Writing the key UNLOCK_KEY (default 32'h1ACCE55D) to address 12 makes the lock word read 0. Writing any other value to address 12 makes it read 1.
- R6: While the lock word reads 1, writes to the commit mask (address 13) are ignored.
- R7: `slew_o[i]` equals the stored slew bit of pin i AND the 8 mA weight bit AND (the 4 mA or the 12 mA weight bit). Otherwise it is 0.
- R8: Read data follows `addr` in the same cycle, zero-extended to 32 bits. Addresses 14 and 15 read as zero.
- R9: Every per-pin output always equals the stored register of the same name.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 4 | Word address |
| we | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| dir_o | output | 8 | Output direction per pin |
| den_o | output | 8 | Digital enable per pin |
| ams_o | output | 8 | Analog select per pin |
| afe_o | output | 8 | Alternate-function enable per pin |
| fsel_o | output | 32 | Packed 4-bit function codes |
| pup_o | output | 8 | Pull-up enable per pin |
| pdn_o | output | 8 | Pull-down enable per pin |
| ods_o | output | 8 | Open-drain select per pin |
| drv4_o | output | 8 | 4 mA weight per pin |
| drv8_o | output | 8 | 8 mA weight per pin |
| drv12_o | output | 8 | 12 mA weight per pin |
| slew_o | output | 8 | Gated slew request per pin |

## Verification
The hardest situation to reach is a change to a protected pin that actually takes effect. It needs three writes in a fixed order:
- the key written to the lock word,
- a commit mask that opens the pin,
- the configuration write itself.

The stimulus also needs the near misses. These are a commit write with the lock still set, and a wrong key that re-locks the lock word. The bench scripts these sequences and then mixes random writes whose addresses include the lock and commit words, with the key appearing often.

// File: rtl/gpio_padcfg.sv
module gpio_padcfg #(
  parameter int NPINS = 8,
  parameter int FW = 4,
  parameter int DW = 32,
  parameter int AW = 4,
  parameter logic [DW-1:0] UNLOCK_KEY = 32'h1ACCE55D,
  parameter logic [NPINS-1:0] PROT_PINS = 8'h0C
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      addr,
  input  logic               we,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  output logic [NPINS-1:0]   dir_o,
  output logic [NPINS-1:0]   den_o,
  output logic [NPINS-1:0]   ams_o,
  output logic [NPINS-1:0]   afe_o,
  output logic [FW*NPINS-1:0] fsel_o,
  output logic [NPINS-1:0]   pup_o,
  output logic [NPINS-1:0]   pdn_o,
  output logic [NPINS-1:0]   ods_o,
  output logic [NPINS-1:0]   drv4_o,
  output logic [NPINS-1:0]   drv8_o,
  output logic [NPINS-1:0]   drv12_o,
  output logic [NPINS-1:0]   slew_o
);
  localparam int FSW = FW * NPINS;
  localparam logic [AW-1:0] A_DIR = 0, A_DEN = 1, A_AMS = 2, A_AFE = 3, A_FSEL = 4,
                            A_PUP = 5, A_PDN = 6, A_ODS = 7, A_DRV4 = 8, A_DRV8 = 9,
                            A_DRV12 = 10, A_SLEW = 11, A_LOCK = 12, A_CMT = 13;

  logic [NPINS-1:0] dir_q, den_q, ams_q, afe_q, pup_q, pdn_q, ods_q;
  logic [NPINS-1:0] drv4_q, drv8_q, drv12_q, slew_q, commit_q;
  logic [FSW-1:0]   fsel_q;
  logic             locked_q;

  wire [NPINS-1:0] wv  = wdata[NPINS-1:0];
  wire [NPINS-1:0] wset = wv & commit_q;
  wire [NPINS-1:0] wmerge_den = (den_q & ~commit_q) | wset;
  wire [NPINS-1:0] wmerge_afe = (afe_q & ~commit_q) | wset;
  wire [NPINS-1:0] wmerge_pup = (pup_q & ~commit_q) | wset;
  wire [NPINS-1:0] wmerge_pdn = (pdn_q & ~commit_q) | wset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0; den_q <= '0; ams_q <= '0; afe_q <= '0;
      pup_q <= '0; pdn_q <= '0; ods_q <= '0;
      drv4_q <= '0; drv8_q <= '0; drv12_q <= '0; slew_q <= '0;
      fsel_q <= '0;
      commit_q <= ~PROT_PINS;
      locked_q <= 1'b1;
    end else if (we) begin
      case (addr)
        A_DIR:   dir_q <= wv;
        A_DEN:   den_q <= wmerge_den;
        A_AMS:   ams_q <= wv;
        A_AFE:   afe_q <= wmerge_afe;
        A_FSEL:  fsel_q <= wdata[FSW-1:0];
        A_PUP: begin
          pup_q <= wmerge_pup;
          pdn_q <= pdn_q & ~wset;
        end
        A_PDN: begin
          pdn_q <= wmerge_pdn;
          pup_q <= pup_q & ~wset;
        end
        A_ODS:   ods_q <= wv;
        A_DRV4:  drv4_q <= wv;
        A_DRV8:  drv8_q <= wv;
        A_DRV12: drv12_q <= wv;
        A_SLEW:  slew_q <= wv;
        A_LOCK:  locked_q <= (wdata != UNLOCK_KEY);
        A_CMT:   if (!locked_q) commit_q <= wv;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_DIR:   rdata[NPINS-1:0] = dir_q;
      A_DEN:   rdata[NPINS-1:0] = den_q;
      A_AMS:   rdata[NPINS-1:0] = ams_q;
      A_AFE:   rdata[NPINS-1:0] = afe_q;
      A_FSEL:  rdata[FSW-1:0]   = fsel_q;
      A_PUP:   rdata[NPINS-1:0] = pup_q;
      A_PDN:   rdata[NPINS-1:0] = pdn_q;
      A_ODS:   rdata[NPINS-1:0] = ods_q;
      A_DRV4:  rdata[NPINS-1:0] = drv4_q;
      A_DRV8:  rdata[NPINS-1:0] = drv8_q;
      A_DRV12: rdata[NPINS-1:0] = drv12_q;
      A_SLEW:  rdata[NPINS-1:0] = slew_q;
      A_LOCK:  rdata[0]         = locked_q;
      A_CMT:   rdata[NPINS-1:0] = commit_q;
      default: rdata = '0;
    endcase
  end

  assign dir_o   = dir_q;
  assign den_o   = den_q;
  assign ams_o   = ams_q;
  assign afe_o   = afe_q;
  assign fsel_o  = fsel_q;
  assign pup_o   = pup_q;
  assign pdn_o   = pdn_q;
  assign ods_o   = ods_q;
  assign drv4_o  = drv4_q;
  assign drv8_o  = drv8_q;
  assign drv12_o = drv12_q;
  assign slew_o  = slew_q & drv8_q & (drv4_q | drv12_q);
endmodule

// File: rtl/gpio_padcfg_chk.sv
module gpio_padcfg_chk #(
  parameter int NPINS = 8,
  parameter int FW = 4,
  parameter int DW = 32,
  parameter int AW = 4,
  parameter logic [DW-1:0] UNLOCK_KEY = 32'h1ACCE55D
) (
  input logic                clk,
  input logic                rst_n,
  input logic [AW-1:0]       addr,
  input logic                we,
  input logic [DW-1:0]       wdata,
  input logic [NPINS-1:0]    afe_o,
  input logic [FW*NPINS-1:0] fsel_o,
  input logic [NPINS-1:0]    pup_o,
  input logic [NPINS-1:0]    pdn_o,
  input logic [NPINS-1:0]    drv8_o,
  input logic [NPINS-1:0]    slew_o,
  input logic [NPINS-1:0]    commit_q,
  input logic                locked_q
);
  localparam int FSW = FW * NPINS;
  localparam logic [AW-1:0] C_AFE = 3, C_FSEL = 4, C_LOCK = 12, C_CMT = 13;

  p_fsel_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == C_FSEL) |=> fsel_o == $past(wdata[FSW-1:0]));

  p_pull_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pup_o & pdn_o) == '0);

  p_commit_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == C_AFE) |=> ((afe_o ^ $past(afe_o)) & ~$past(commit_q)) == '0);

  p_unlock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == C_LOCK && wdata == UNLOCK_KEY) |=> !locked_q);

  p_commit_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == C_CMT && locked_q) |=> $stable(commit_q));

  p_slew_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (slew_o & ~drv8_o) == '0);
endmodule

bind gpio_padcfg gpio_padcfg_chk #(.NPINS(NPINS), .FW(FW), .DW(DW), .AW(AW), .UNLOCK_KEY(UNLOCK_KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
  .afe_o(afe_o), .fsel_o(fsel_o), .pup_o(pup_o), .pdn_o(pdn_o),
  .drv8_o(drv8_o), .slew_o(slew_o), .commit_q(commit_q), .locked_q(locked_q)
);

// File: tb/gpio_padcfg_tb.sv
module gpio_padcfg_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h1ACCE55D;
  localparam logic [7:0] PROT = 8'h0C;

  logic clk = 0, rst_n = 0, we = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [7:0] dir_o, den_o, ams_o, afe_o, pup_o, pdn_o, ods_o, drv4_o, drv8_o, drv12_o, slew_o;
  logic [31:0] fsel_o;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [7:0] mreg [0:15];
  logic [31:0] mfsel;
  logic mlock;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_padcfg u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata), .rdata(rdata),
    .dir_o(dir_o), .den_o(den_o), .ams_o(ams_o), .afe_o(afe_o), .fsel_o(fsel_o),
    .pup_o(pup_o), .pdn_o(pdn_o), .ods_o(ods_o), .drv4_o(drv4_o), .drv8_o(drv8_o),
    .drv12_o(drv12_o), .slew_o(slew_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) mreg[i] = 8'h00;
    mreg[13] = ~PROT;
    mfsel = 0;
    mlock = 1;
  endtask

  function automatic logic [31:0] model_read(input int a);
    if (a == 4) return mfsel;
    if (a == 12) return {31'b0, mlock};
    if (a <= 13) return {24'b0, mreg[a]};
    return 32'h0;
  endfunction

  task automatic model_write(input int a, input logic [31:0] d);
    logic [7:0] v, c;
    v = d[7:0];
    c = mreg[13];
    case (a)
      1, 3: mreg[a] = (mreg[a] & ~c) | (v & c);
      4: mfsel = d;
      5: begin mreg[5] = (mreg[5] & ~c) | (v & c); mreg[6] = mreg[6] & ~(v & c); end
      6: begin mreg[6] = (mreg[6] & ~c) | (v & c); mreg[5] = mreg[5] & ~(v & c); end
      12: mlock = (d != KEY);
      13: if (!mlock) mreg[13] = v;
      0, 2, 7, 8, 9, 10, 11: mreg[a] = v;
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else if (we) model_write(int'(addr), wdata);
    #2;
    if (rst_n) begin
      chk("R9 dir", {24'b0, dir_o}, {24'b0, mreg[0]});
      chk("R4 den", {24'b0, den_o}, {24'b0, mreg[1]});
      chk("R9 ams", {24'b0, ams_o}, {24'b0, mreg[2]});
      chk("R4 afe", {24'b0, afe_o}, {24'b0, mreg[3]});
      chk("R2 fsel", fsel_o, mfsel);
      chk("R3 pup", {24'b0, pup_o}, {24'b0, mreg[5]});
      chk("R3 pdn", {24'b0, pdn_o}, {24'b0, mreg[6]});
      chk("R9 ods", {24'b0, ods_o}, {24'b0, mreg[7]});
      chk("R9 drv", {8'b0, drv4_o, drv8_o, drv12_o}, {8'b0, mreg[8], mreg[9], mreg[10]});
      chk("R7 slew", {24'b0, slew_o}, {24'b0, mreg[11] & mreg[9] & (mreg[8] | mreg[10])});
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = a[3:0]; wdata = d; we = 1;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input string tag, input int a);
    @(negedge clk);
    we = 0; addr = a[3:0];
    #1;
    chk(tag, rdata, model_read(a));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state; R8 unmapped reads
    for (int a = 0; a < 16; a++) rd("R1/R8 reset read", a);
    chk("R1 lock", rdata, 32'h0);
    rd("R1 lock reads 1", 12);
    chk("R1 lock value", rdata, 32'h1);
    rd("R1 commit", 13);
    chk("R1 commit value", rdata, 32'h000000F3);
    // R2 plain registers and packed function codes
    wr(0, 32'hFFFF_FFA5); rd("R2 dir", 0);
    wr(2, 32'h3C); rd("R2 ams", 2);
    wr(7, 32'h81); rd("R2 ods", 7);
    wr(4, 32'h7654_3210); rd("R2 fsel", 4);
    for (int i = 0; i < 8; i++) chk("R2 fsel field", {28'b0, fsel_o[4*i +: 4]}, i);
    // R4 protected bits ignored
    wr(3, 32'hFF); rd("R4 afe gated", 3); chk("R4 afe value", rdata, 32'hF3);
    wr(1, 32'hFF); rd("R4 den gated", 1); chk("R4 den value", rdata, 32'hF3);
    // R3 pull exclusivity
    wr(5, 32'hFF); rd("R3 pup", 5); chk("R3 pup value", rdata, 32'hF3);
    wr(6, 32'h0F); rd("R3 pdn", 6); chk("R3 pdn value", rdata, 32'h03);
    rd("R3 pup cleared", 5); chk("R3 pup after pdn", rdata, 32'hF0);
    // R6 commit ignored while locked
    wr(13, 32'hFF); rd("R6 commit locked", 13); chk("R6 commit value", rdata, 32'hF3);
    // R5 key handling
    wr(12, 32'h1ACCE55C); rd("R5 wrong key", 12); chk("R5 still locked", rdata, 32'h1);
    wr(12, KEY); rd("R5 unlocked", 12); chk("R5 reads 0", rdata, 32'h0);
    wr(13, 32'hFF); rd("R6 commit unlocked", 13); chk("R6 commit open", rdata, 32'hFF);
    wr(12, 32'h0); rd("R5 relock", 12); chk("R5 relocked", rdata, 32'h1);
    wr(3, 32'hFF); rd("R4 afe open", 3); chk("R4 afe full", rdata, 32'hFF);
    wr(6, 32'h0C); rd("R3 protected pull", 5); chk("R3 pup cleared prot", rdata, 32'hF0);
    // R7 slew gating
    wr(11, 32'hFF); wr(8, 32'hAA); wr(9, 32'hCC); wr(10, 32'hF0);
    @(negedge clk); chk("R7 slew pattern", {24'b0, slew_o}, 32'hC8);
    rd("R7 slew stored", 11); chk("R7 slew reg", rdata, 32'hFF);
    // random mix
    for (int n = 0; n < 600; n++) begin
      int a;
      logic [31:0] d;
      a = int'($urandom_range(0, 15));
      d = $urandom;
      if (a == 12 && ($urandom_range(0, 1) == 1)) d = KEY;
      wr(a, d);
      rd("R8 random read", int'($urandom_range(0, 15)));
    end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule